// File: doc/BRIEF.md
# Single-port parallel I/O controller

This block is a small parallel I/O peripheral that sits on a microprocessor bus. The processor reaches four registers through one address bit, a chip enable and separate read and write strobes. The block has a single 8-bit peripheral port, and the control register sets it to work either as an input or as an output. The port can run without handshake (Mode 0) or with a strobe and acknowledge handshake (Mode 1). In Mode 1 the block raises an interrupt request when that request is enabled.

All bus strobes and handshake lines come from outside and are asynchronous to the system clock. The block passes them through a two-stage synchronizer and then detects their edges, so that a held strobe takes effect only once. The data bus is split into an input, an output and an output enable, and the enable is high only while a valid read is in progress. Address and write data must stay stable while a strobe is held low.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset the port is an input in Mode 0 with interrupts disabled. `port_oe` is 0, `intr` is 0, `ibf` is 0, `obf_n` is 1, and a status read returns 8'h01.
- R2: The address bit selects the register. With `addr`=0 a write loads the output data register and a read returns the input data register. With `addr`=1 a write loads the control register from `dbus_in[2:0]` (bit 0 is the mode, 1 meaning Mode 1; bit 1 is the interrupt enable; bit 2 is the direction, 1 meaning input). With `addr`=1 a read returns the status {4'b0, ibf (bit 3), intr (bit 2), interrupt enable (bit 1), obf_n (bit 0)}.
- R3: A register is accessed only while `cs_n` and the matching strobe are both low. A write strobe with `cs_n` high changes nothing. `dbus_oe` is 1 only during a valid read, and `dbus_out` is 0 at all other times.
- R4: Every strobe, acknowledge and bus access acts once per falling (or, where stated, rising) edge, however long it is held. Its effect appears after the third rising clock edge that follows the raw change. `dbus_oe` follows a read after the second rising edge.
- R5: `port_oe` is the inverse of the direction bit, and `port_out` always shows the output data register.
- R6: In Mode 0 input, a data read returns `port_in` as sampled on the previous clock, and `ibf` and `intr` stay 0.
- R7: In Mode 0 output, a data write appears on `port_out`, and `obf_n` stays 1 with no interrupt.
- R8: In Mode 1 input, a falling `stb_n` latches `port_in` into the input data register and sets `ibf`. When `stb_n` then rises while `ibf` is set and interrupts are enabled, the interrupt request is raised. Later changes on `port_in` do not alter the latched value.
- R9: In Mode 1 input, the start of a data read clears `ibf` and the interrupt request. If a strobe fall lands in the same cycle as the read start, `ibf` stays set. If a strobe rise lands in the same cycle as the read start, no interrupt is raised.
- R10: In Mode 1 output, a data write drives `obf_n` low and clears the interrupt request. A falling `ack_n` returns `obf_n` high. A rising `ack_n` with interrupts enabled raises the request. A write that starts in the same cycle as an `ack_n` rise wins: `obf_n` goes low and `intr` stays 0.
- R11: `intr` is 1 only while the interrupt enable is 1. A control write clears the interrupt request and `ibf`, and returns `obf_n` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Reset, active high |
| cs_n | input | 1 | Chip enable, active low |
| addr | input | 1 | Register select bit |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dbus_in | input | 8 | Data bus input from the processor |
| dbus_out | output | 8 | Data bus value driven on a read |
| dbus_oe | output | 1 | Data bus output enable |
| intr | output | 1 | Interrupt request |
| port_in | input | 8 | Peripheral port input value |
| port_out | output | 8 | Peripheral port output value |
| port_oe | output | 1 | Peripheral port output enable |
| stb_n | input | 1 | Peripheral input strobe, active low |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |

## Verification
Two functions can fall in the same clock: a handshake edge on `stb_n` or `ack_n`, and the start of a processor data access. The bench provokes this by changing the raw handshake line and the raw bus strobes at the same falling clock edge. Both signals go through the same synchronizer depth, so their detected edges meet in a single cycle. The resulting `ibf`, `obf_n` and `intr` are judged against the priorities in R9 and R10, and a behavioural model checks every output on every clock.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DATA_W = 8;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic dir;   // 1 = input
    logic inte;  // interrupt enable
    logic mode;  // 1 = handshaked
  } pio_ctrl_t;

  localparam pio_ctrl_t CTRL_RESET = '{dir: 1'b1, inte: 1'b0, mode: 1'b0};
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int LINES  = 1,
  parameter int STAGES = 2,
  parameter logic [LINES-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl
);
  logic [LINES-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or posedge rst)
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= raw;
      end else begin : g_next
        always_ff @(posedge clk or posedge rst)
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/pio_bus.sv
module pio_bus
  import pio_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_l,
  input  logic          rd_l,
  input  logic          wr_l,
  input  logic          addr,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] data_in,
  input  logic          ibf,
  input  logic          obf_n,
  input  logic          intr,
  output logic [DW-1:0] dout,
  output logic          oe,
  output pio_ctrl_t     ctrl,
  output logic [DW-1:0] data_out,
  output logic          wr_data_p,
  output logic          wr_ctrl_p,
  output logic          rd_data_p
);
  logic rd_act, wr_act, rd_q, wr_q, rd_start, wr_start;
  logic [DW-1:0] status;

  assign rd_act   = !cs_l && !rd_l;
  assign wr_act   = !cs_l && !wr_l;
  assign rd_start = rd_act && !rd_q;
  assign wr_start = wr_act && !wr_q;

  assign wr_data_p = wr_start && !addr;
  assign wr_ctrl_p = wr_start &&  addr;
  assign rd_data_p = rd_start && !addr;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      ctrl     <= CTRL_RESET;
      data_out <= '0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (wr_ctrl_p) ctrl     <= pio_ctrl_t'(din[2:0]);
      if (wr_data_p) data_out <= din;
    end
  end

  always_comb begin
    status    = '0;
    status[0] = obf_n;
    status[1] = ctrl.inte;
    status[2] = intr;
    status[3] = ibf;
  end

  assign oe   = rd_act;
  assign dout = !rd_act ? '0 : (addr ? status : data_in);

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl_p |=> $stable(ctrl)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_data_p |=> $stable(data_out)); // R3
endmodule

// File: rtl/pio_hs.sv
module pio_hs
  import pio_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  pio_ctrl_t     ctrl,
  input  logic          stb_l,
  input  logic          ack_l,
  input  logic [DW-1:0] port_in,
  input  logic          wr_data_p,
  input  logic          wr_ctrl_p,
  input  logic          rd_data_p,
  output logic [DW-1:0] data_in,
  output logic          ibf,
  output logic          obf_n,
  output logic          intr
);
  logic stb_q, ack_q, ibf_q, obf_q, intr_q;
  logic stb_fall, stb_rise, ack_fall, ack_rise, m1_in, m1_out;

  assign stb_fall = stb_q && !stb_l;
  assign stb_rise = !stb_q && stb_l;
  assign ack_fall = ack_q && !ack_l;
  assign ack_rise = !ack_q && ack_l;
  assign m1_in    = ctrl.mode && ctrl.dir;
  assign m1_out   = ctrl.mode && !ctrl.dir;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stb_q   <= 1'b1;
      ack_q   <= 1'b1;
      data_in <= '0;
      ibf_q   <= 1'b0;
      obf_q   <= 1'b1;
      intr_q  <= 1'b0;
    end else begin
      stb_q <= stb_l;
      ack_q <= ack_l;
      if (!ctrl.mode && ctrl.dir) data_in <= port_in;
      if (wr_ctrl_p) begin
        ibf_q  <= 1'b0;
        obf_q  <= 1'b1;
        intr_q <= 1'b0;
      end else if (m1_in) begin
        if (stb_fall) begin
          data_in <= port_in;
          ibf_q   <= 1'b1;
        end else if (rd_data_p) begin
          ibf_q <= 1'b0;
        end
        if (rd_data_p) intr_q <= 1'b0;
        else if (stb_rise && ibf_q && ctrl.inte) intr_q <= 1'b1;
      end else if (m1_out) begin
        if (wr_data_p) begin
          obf_q  <= 1'b0;
          intr_q <= 1'b0;
        end else begin
          if (ack_fall) obf_q <= 1'b1;
          if (ack_rise && ctrl.inte) intr_q <= 1'b1;
        end
      end
    end
  end

  assign ibf   = ibf_q;
  assign obf_n = obf_q;
  assign intr  = intr_q && ctrl.inte;

  AST_INTR_GATED: assert property (@(posedge clk) disable iff (rst)
    intr_q |-> ctrl.inte); // R11
  AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl.mode |-> (!ibf_q && !intr_q && obf_q)); // R7
  AST_STB_LATCH: assert property (@(posedge clk) disable iff (rst)
    (m1_in && stb_fall && !wr_ctrl_p) |=> ibf_q); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (m1_in && rd_data_p && !stb_fall && !wr_ctrl_p) |=> (!ibf_q && !intr_q)); // R9
  AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (m1_out && wr_data_p && !wr_ctrl_p) |=> (!obf_q && !intr_q)); // R10
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] dbus_in,
  output logic [DW-1:0] dbus_out,
  output logic          dbus_oe,
  output logic          intr,
  input  logic [DW-1:0] port_in,
  output logic [DW-1:0] port_out,
  output logic          port_oe,
  input  logic          stb_n,
  output logic          ibf,
  output logic          obf_n,
  input  logic          ack_n
);
  localparam int LINES = 5;

  logic [LINES-1:0] raw_lines, sync_lines;
  pio_ctrl_t        ctrl;
  logic [DW-1:0]    data_in, data_out;
  logic             wr_data_p, wr_ctrl_p, rd_data_p;

  assign raw_lines = {ack_n, stb_n, wr_n, rd_n, cs_n};

  pio_sync #(.LINES(LINES), .STAGES(STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .raw(raw_lines), .lvl(sync_lines)
  );

  pio_bus #(.DW(DW)) u_bus (
    .clk(clk), .rst(rst),
    .cs_l(sync_lines[0]), .rd_l(sync_lines[1]), .wr_l(sync_lines[2]),
    .addr(addr), .din(dbus_in),
    .data_in(data_in), .ibf(ibf), .obf_n(obf_n), .intr(intr),
    .dout(dbus_out), .oe(dbus_oe), .ctrl(ctrl), .data_out(data_out),
    .wr_data_p(wr_data_p), .wr_ctrl_p(wr_ctrl_p), .rd_data_p(rd_data_p)
  );

  pio_hs #(.DW(DW)) u_hs (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .stb_l(sync_lines[3]), .ack_l(sync_lines[4]), .port_in(port_in),
    .wr_data_p(wr_data_p), .wr_ctrl_p(wr_ctrl_p), .rd_data_p(rd_data_p),
    .data_in(data_in), .ibf(ibf), .obf_n(obf_n), .intr(intr)
  );

  assign port_out = data_out;
  assign port_oe  = !ctrl.dir;
endmodule

// File: tb/pio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module pio_port_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, addr = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] dbus_in = 8'h00, port_in = 8'h00;
  logic stb_n = 1'b1, ack_n = 1'b1;
  logic [7:0] dbus_out, port_out;
  logic dbus_oe, intr, port_oe, ibf, obf_n;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pio_port_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .dbus_in(dbus_in), .dbus_out(dbus_out), .dbus_oe(dbus_oe), .intr(intr),
    .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
    .stb_n(stb_n), .ibf(ibf), .obf_n(obf_n), .ack_n(ack_n)
  );

  // Behavioural reference model, line order {ack, stb, wr, rd, cs}
  logic [4:0] c1, c2;
  logic m_stbq, m_ackq, m_rdq, m_wrq;
  logic m_dir, m_inte, m_mode, m_ibf, m_obfn, m_intrq;
  logic [7:0] m_din, m_dreg;

  always @(posedge clk) begin
    if (rst) begin
      c1 = '1; c2 = '1; m_stbq = 1; m_ackq = 1; m_rdq = 0; m_wrq = 0;
      m_dir = 1; m_inte = 0; m_mode = 0; m_ibf = 0; m_obfn = 1; m_intrq = 0;
      m_din = 0; m_dreg = 0;
    end else begin
      logic rda, wra, rds, wrs, stbf, stbr, ackf, ackr, m1i, m1o, o_inte, o_ibf;
      rda = !c2[0] && !c2[1];
      wra = !c2[0] && !c2[2];
      rds = rda && !m_rdq && !addr;
      wrs = wra && !m_wrq;
      stbf = m_stbq && !c2[3]; stbr = !m_stbq && c2[3];
      ackf = m_ackq && !c2[4]; ackr = !m_ackq && c2[4];
      m1i = m_mode && m_dir; m1o = m_mode && !m_dir;
      o_inte = m_inte; o_ibf = m_ibf;
      if (!m_mode && m_dir) m_din = port_in;
      if (wrs && addr) begin
        m_dir = dbus_in[2]; m_inte = dbus_in[1]; m_mode = dbus_in[0];
        m_ibf = 0; m_obfn = 1; m_intrq = 0;
      end else begin
        if (wrs) m_dreg = dbus_in;
        if (m1i) begin
          if (stbf) begin m_din = port_in; m_ibf = 1; end
          else if (rds) m_ibf = 0;
          if (rds) m_intrq = 0;
          else if (stbr && o_ibf && o_inte) m_intrq = 1;
        end else if (m1o) begin
          if (wrs) begin m_obfn = 0; m_intrq = 0; end
          else begin
            if (ackf) m_obfn = 1;
            if (ackr && o_inte) m_intrq = 1;
          end
        end
      end
      m_rdq = rda; m_wrq = wra; m_stbq = c2[3]; m_ackq = c2[4];
      c2 = c1; c1 = {ack_n, stb_n, wr_n, rd_n, cs_n};
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      logic oe;
      logic [7:0] st, dv;
      oe = !c2[0] && !c2[1];
      st = {4'b0, m_ibf, m_intrq && m_inte, m_inte, m_obfn};
      dv = !oe ? 8'h00 : (addr ? st : m_din);
      chk("R3", "model dbus_oe", {7'b0, dbus_oe}, {7'b0, oe});
      chk("R2", "model dbus_out", dbus_out, dv);
      chk("R11", "model intr", {7'b0, intr}, {7'b0, m_intrq && m_inte});
      chk("R5", "model port_out", port_out, m_dreg);
      chk("R5", "model port_oe", {7'b0, port_oe}, {7'b0, !m_dir});
      chk("R8", "model ibf", {7'b0, ibf}, {7'b0, m_ibf});
      chk("R10", "model obf_n", {7'b0, obf_n}, {7'b0, m_obfn});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; dbus_in = d; cs_n = 0; wr_n = 0;
    cyc(4); wr_n = 1; cs_n = 1; cyc(4);
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; cs_n = 0; rd_n = 0;
    cyc(4); d = dbus_out; rd_n = 1; cs_n = 1; cyc(4);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] d;
    cyc(4); rst = 0; cyc(1); cmp_on = 1;

    // R1 reset state
    chk("R1", "port_oe", {7'b0, port_oe}, 8'h00);
    chk("R1", "intr", {7'b0, intr}, 8'h00);
    chk("R3", "idle dbus_oe", {7'b0, dbus_oe}, 8'h00);
    bus_rd(1, d); chk("R1", "status", d, 8'h01);

    // R3 write with chip enable high is ignored
    @(negedge clk); addr = 1; dbus_in = 8'h03; wr_n = 0; cyc(4); wr_n = 1; cyc(4);
    chk("R3", "ignored write port_oe", {7'b0, port_oe}, 8'h00);
    bus_rd(1, d); chk("R3", "ignored write status", d, 8'h01);

    // R6 Mode 0 input
    port_in = 8'hA5; cyc(2);
    bus_rd(0, d); chk("R6", "mode0 read", d, 8'hA5);
    port_in = 8'h3C; cyc(2);
    bus_rd(0, d); chk("R6", "mode0 read 2", d, 8'h3C);
    chk("R6", "mode0 ibf", {7'b0, ibf}, 8'h00);

    // R5 R7 Mode 0 output, R2 decode
    bus_wr(1, 8'h00);
    chk("R5", "output port_oe", {7'b0, port_oe}, 8'h01);
    bus_wr(0, 8'h5A);
    chk("R7", "mode0 port_out", port_out, 8'h5A);
    chk("R7", "mode0 obf_n", {7'b0, obf_n}, 8'h01);
    bus_rd(1, d); chk("R2", "data write left ctrl", d, 8'h01);
    bus_wr(1, 8'h02);
    bus_rd(1, d); chk("R2", "inte status bit", d, 8'h03);
    chk("R2", "ctrl write left data", port_out, 8'h5A);

    // R8 R9 Mode 1 input
    bus_wr(1, 8'h07);
    port_in = 8'hC3;
    @(negedge clk); stb_n = 0;
    cyc(2); chk("R4", "ibf before third edge", {7'b0, ibf}, 8'h00);
    cyc(1); chk("R4", "ibf after third edge", {7'b0, ibf}, 8'h01);
    cyc(2); chk("R8", "no intr while strobe low", {7'b0, intr}, 8'h00);
    stb_n = 1; cyc(4);
    chk("R8", "intr on strobe rise", {7'b0, intr}, 8'h01);
    bus_rd(1, d); chk("R2", "status full", d, 8'h0F);
    port_in = 8'h11; cyc(2);
    bus_rd(0, d); chk("R8", "latched value held", d, 8'hC3);
    chk("R9", "read clears ibf", {7'b0, ibf}, 8'h00);
    chk("R9", "read clears intr", {7'b0, intr}, 8'h00);

    // R9 strobe fall coincides with read start
    port_in = 8'h77;
    @(negedge clk); stb_n = 0; addr = 0; cs_n = 0; rd_n = 0;
    cyc(4); rd_n = 1; cs_n = 1; cyc(4);
    chk("R9", "latch wins over read", {7'b0, ibf}, 8'h01);
    stb_n = 1; cyc(4);
    chk("R9", "intr after later rise", {7'b0, intr}, 8'h01);
    bus_rd(0, d); chk("R9", "new data read", d, 8'h77);

    // R9 strobe rise coincides with read start
    @(negedge clk); stb_n = 0; cyc(4);
    @(negedge clk); stb_n = 1; addr = 0; cs_n = 0; rd_n = 0;
    cyc(4); rd_n = 1; cs_n = 1; cyc(4);
    chk("R9", "no intr on coincident rise", {7'b0, intr}, 8'h00);
    chk("R9", "ibf cleared", {7'b0, ibf}, 8'h00);

    // R10 Mode 1 output
    bus_wr(1, 8'h03);
    bus_wr(0, 8'h96);
    chk("R10", "obf_n low after write", {7'b0, obf_n}, 8'h00);
    chk("R10", "port_out", port_out, 8'h96);
    @(negedge clk); ack_n = 0; cyc(4);
    chk("R10", "obf_n high on ack", {7'b0, obf_n}, 8'h01);
    chk("R10", "no intr while ack low", {7'b0, intr}, 8'h00);
    ack_n = 1; cyc(4);
    chk("R10", "intr on ack rise", {7'b0, intr}, 8'h01);

    // R4 held write acts once
    @(negedge clk); addr = 0; dbus_in = 8'h4B; cs_n = 0; wr_n = 0; cyc(4);
    chk("R4", "held write obf_n", {7'b0, obf_n}, 8'h00);
    ack_n = 0; cyc(4); ack_n = 1; cyc(8);
    chk("R4", "held write not repeated", {7'b0, obf_n}, 8'h01);
    wr_n = 1; cs_n = 1; cyc(4);

    // R10 write coincides with ack rise
    @(negedge clk); ack_n = 0; cyc(4);
    @(negedge clk); ack_n = 1; addr = 0; dbus_in = 8'h2D; cs_n = 0; wr_n = 0;
    cyc(4); wr_n = 1; cs_n = 1; cyc(4);
    chk("R10", "write wins obf_n", {7'b0, obf_n}, 8'h00);
    chk("R10", "write wins intr", {7'b0, intr}, 8'h00);
    chk("R10", "write wins data", port_out, 8'h2D);

    // R11 interrupt enable gating
    @(negedge clk); ack_n = 0; cyc(4); ack_n = 1; cyc(4);
    chk("R11", "intr raised", {7'b0, intr}, 8'h01);
    bus_wr(1, 8'h01);
    chk("R11", "intr dropped by ctrl write", {7'b0, intr}, 8'h00);
    bus_wr(0, 8'h10);
    @(negedge clk); ack_n = 0; cyc(4); ack_n = 1; cyc(4);
    chk("R11", "no intr when disabled", {7'b0, intr}, 8'h00);
    bus_rd(1, d); chk("R11", "status intr bit", d, 8'h01);

    cyc(4);
    summary();
  end
endmodule